// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical page after the translation cache has missed. A walk starts from a directory base register. The walker reads the directory entry and then the table entry from memory, one word at a time. It checks that both entries are present. It sets the accessed and dirty flags by writing the changed entry back to memory. When the walk ends, it reports either the physical page number with the page's permission bits, or a page fault.

The walker handles one walk at a time. A new walk may be started only while `walk_busy` is low. Memory traffic uses a single request/response port. A request stays on the port until the memory grants it. Every granted request, read or write, is answered later by exactly one response pulse. Large pages are not supported.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to the directory entry at byte address {dir_base, va[31:22], 2'b00}.
- R2: The second read of a walk goes to the table entry at byte address {directory entry bits [31:12], va[21:12], 2'b00}.
- R3: The walk ends with `done_fault` high and `done_ppn`/`done_paddr` zero if the present bit (bit 0) is clear in the directory entry or in the table entry. A fault at the directory entry issues no table read.
- R4: A present directory entry whose page-size bit (bit 7) is set ends the walk in a fault, with no write and no further read.
- R5: When the accessed bit (bit 5) of a present, small-page directory entry is clear, the walker writes that entry back with bit 5 set and all other bits unchanged. When bit 5 is already set, no write is made.
- R6: For a present table entry, the walker sets the accessed bit (bit 5) on every walk and the dirty bit (bit 6) only on a write walk. The entry is written back only if one of these bits changes.
- R7: A successful walk returns the table entry's bits [31:12] as `done_ppn`, and {ppn, va[11:0]} as `done_paddr`. It also returns the entry's bit 8 as `done_global`, bit 2 as `done_user` and bit 1 as `done_writable`, with `done_fault` low.
- R8: `done_valid` is a one-cycle pulse. It rises in the cycle after the cycle in which the walk's final memory response arrives.
- R9: A memory request holds its address, write enable and write data stable until it is granted. No new request is made until the previous request has been answered.
- R10: `walk_req` has no effect while `walk_busy` is high: no second result and no extra memory access follow.
- R11: After reset, `walk_busy`, `done_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_base | input | 20 | Page-frame number of the page directory |
| walk_req | input | 1 | Start a walk (taken only while idle) |
| walk_va | input | 32 | Virtual address to translate |
| walk_write | input | 1 | The access that missed is a store |
| walk_busy | output | 1 | A walk is in progress |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | The walk ended in a page fault |
| done_ppn | output | 20 | Physical page number |
| done_paddr | output | 32 | Full physical address |
| done_global | output | 1 | Global-page bit of the table entry |
| done_user | output | 1 | User-accessible bit of the table entry |
| done_writable | output | 1 | Writable bit of the table entry |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Response pulse (read data or write acknowledge) |
| mem_rdata | input | 32 | Read data |

## Verification
The only fixed latency is at the end of a walk: the result is due exactly one cycle after the final memory response. The bench records whether a response was present at each falling-edge sample, and it requires `done_valid` to appear at the very next sample. Everything before that depends on how the memory model stalls grants and delays responses, so the bench waits for the result without fixing an arrival time. It then compares the result, the log of read addresses, the number of writes and the final memory contents with values computed from the entry encodings. After each result the bench watches six more cycles to confirm that the walk has ended cleanly.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_RD_DIR,
      WK_WR_DIR,
      WK_RD_TBL,
      WK_WR_TBL,
      WK_DONE,
      WK_FAULT
   } walk_state_e;

   localparam int unsigned BIT_P  = 0;
   localparam int unsigned BIT_RW = 1;
   localparam int unsigned BIT_US = 2;
   localparam int unsigned BIT_A  = 5;
   localparam int unsigned BIT_D  = 6;
   localparam int unsigned BIT_PS = 7;
   localparam int unsigned BIT_G  = 8;

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX_W  = 10
) (
   input  logic [ADDR_W-OFF_W-1:0] dir_frame,
   input  logic [ADDR_W-OFF_W-1:0] tbl_frame,
   input  logic [ADDR_W-OFF_W-1:0] vpn,
   input  logic                    sel_tbl,
   output logic [ADDR_W-1:0]       entry_addr
);
   localparam int unsigned FRAME_W = ADDR_W - OFF_W;

   if (ADDR_W != OFF_W + 2*IDX_W) begin : g_bad_split
      $error("pt_walk_addr: address must split into two indices and an offset");
   end
   if (OFF_W != IDX_W + 2) begin : g_bad_entry
      $error("pt_walk_addr: a table of 4-byte entries must fill one page");
   end

   logic [IDX_W-1:0] dir_idx;
   logic [IDX_W-1:0] tbl_idx;

   assign dir_idx = vpn[FRAME_W-1 -: IDX_W];
   assign tbl_idx = vpn[IDX_W-1:0];

   always_comb begin
      if (sel_tbl) entry_addr = {tbl_frame, tbl_idx, 2'b00};
      else         entry_addr = {dir_frame, dir_idx, 2'b00};
   end
endmodule

// File: rtl/pt_walk_flags.sv
module pt_walk_flags
   import pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] entry,
   input  logic              is_tbl,
   input  logic              is_write,
   output logic [ADDR_W-1:0] updated,
   output logic              need_wb
);
   if (ADDR_W <= BIT_G) begin : g_bad_width
      $error("pt_walk_flags: entry too narrow for the flag bits");
   end

   always_comb begin
      updated        = entry;
      updated[BIT_A] = 1'b1;
      if (is_tbl && is_write) updated[BIT_D] = 1'b1;
   end

   assign need_wb = (updated != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX_W  = 10,
   localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FRAME_W-1:0] dir_base,
   input  logic               walk_req,
   input  logic [ADDR_W-1:0]  walk_va,
   input  logic               walk_write,
   output logic               walk_busy,
   output logic               done_valid,
   output logic               done_fault,
   output logic [FRAME_W-1:0] done_ppn,
   output logic [ADDR_W-1:0]  done_paddr,
   output logic               done_global,
   output logic               done_user,
   output logic               done_writable,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [ADDR_W-1:0]  mem_wdata,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic [ADDR_W-1:0]  mem_rdata
);
   walk_state_e        state_q;
   logic               issued_q;
   logic [ADDR_W-1:0]  va_q;
   logic               we_q;
   logic [FRAME_W-1:0] base_q;
   logic [ADDR_W-1:0]  pde_q;
   logic [ADDR_W-1:0]  pte_q;

   logic               in_mem_state;
   logic               sel_tbl;
   logic               rsp;
   logic [ADDR_W-1:0]  upd_entry;
   logic               upd_need_wb;

   assign in_mem_state = (state_q == WK_RD_DIR) || (state_q == WK_WR_DIR) ||
                         (state_q == WK_RD_TBL) || (state_q == WK_WR_TBL);
   assign sel_tbl      = (state_q == WK_RD_TBL) || (state_q == WK_WR_TBL);
   assign rsp          = issued_q && mem_rvalid;

   pt_walk_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_addr (
      .dir_frame  (base_q),
      .tbl_frame  (pde_q[ADDR_W-1:OFF_W]),
      .vpn        (va_q[ADDR_W-1:OFF_W]),
      .sel_tbl    (sel_tbl),
      .entry_addr (mem_addr)
   );

   pt_walk_flags #(.ADDR_W(ADDR_W)) i_flags (
      .entry    (mem_rdata),
      .is_tbl   (state_q == WK_RD_TBL),
      .is_write (we_q),
      .updated  (upd_entry),
      .need_wb  (upd_need_wb)
   );

   assign mem_req   = in_mem_state && !issued_q;
   assign mem_we    = (state_q == WK_WR_DIR) || (state_q == WK_WR_TBL);
   assign mem_wdata = (state_q == WK_WR_DIR) ? pde_q : pte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= WK_IDLE;
         issued_q <= 1'b0;
         va_q     <= '0;
         we_q     <= 1'b0;
         base_q   <= '0;
         pde_q    <= '0;
         pte_q    <= '0;
      end else begin
         if (mem_req && mem_gnt) issued_q <= 1'b1;
         else if (rsp)           issued_q <= 1'b0;

         case (state_q)
            WK_IDLE: begin
               if (walk_req) begin
                  va_q    <= walk_va;
                  we_q    <= walk_write;
                  base_q  <= dir_base;
                  state_q <= WK_RD_DIR;
               end
            end
            WK_RD_DIR: begin
               if (rsp) begin
                  if (!mem_rdata[BIT_P] || mem_rdata[BIT_PS]) begin
                     state_q <= WK_FAULT;
                  end else begin
                     pde_q   <= upd_entry;
                     state_q <= upd_need_wb ? WK_WR_DIR : WK_RD_TBL;
                  end
               end
            end
            WK_WR_DIR: if (rsp) state_q <= WK_RD_TBL;
            WK_RD_TBL: begin
               if (rsp) begin
                  if (!mem_rdata[BIT_P]) begin
                     state_q <= WK_FAULT;
                  end else begin
                     pte_q   <= upd_entry;
                     state_q <= upd_need_wb ? WK_WR_TBL : WK_DONE;
                  end
               end
            end
            WK_WR_TBL: if (rsp) state_q <= WK_DONE;
            default:   state_q <= WK_IDLE;
         endcase
      end
   end

   logic ok;
   assign ok = (state_q == WK_DONE);

   assign walk_busy     = (state_q != WK_IDLE);
   assign done_valid    = ok || (state_q == WK_FAULT);
   assign done_fault    = (state_q == WK_FAULT);
   assign done_ppn      = ok ? pte_q[ADDR_W-1:OFF_W] : '0;
   assign done_paddr    = ok ? {pte_q[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
   assign done_global   = ok && pte_q[BIT_G];
   assign done_user     = ok && pte_q[BIT_US];
   assign done_writable = ok && pte_q[BIT_RW];
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned FRAME_W = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               walk_busy,
   input logic               done_valid,
   input logic               done_fault,
   input logic [FRAME_W-1:0] done_ppn,
   input logic               mem_req,
   input logic               mem_we,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic [ADDR_W-1:0]  mem_wdata,
   input logic               mem_gnt,
   input logic               mem_rvalid
);
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   assert_done_after_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(mem_rvalid));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !walk_busy |-> !mem_req && !done_valid);

   assert_wb_accessed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[5] && mem_wdata[0]);

   assert_fault_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_fault |-> done_valid && (done_ppn == '0));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .walk_busy  (walk_busy),
   .done_valid (done_valid),
   .done_fault (done_fault),
   .done_ppn   (done_ppn),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_gnt    (mem_gnt),
   .mem_rvalid (mem_rvalid)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] dir_base = '0;
   logic        walk_req = 1'b0;
   logic [31:0] walk_va = '0;
   logic        walk_write = 1'b0;
   logic        walk_busy, done_valid, done_fault;
   logic [19:0] done_ppn;
   logic [31:0] done_paddr;
   logic        done_global, done_user, done_writable;
   logic        mem_req, mem_we, mem_gnt;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #4 clk = ~clk;

   pt_walker i_pt_walker (
      .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
      .walk_req(walk_req), .walk_va(walk_va), .walk_write(walk_write),
      .walk_busy(walk_busy), .done_valid(done_valid), .done_fault(done_fault),
      .done_ppn(done_ppn), .done_paddr(done_paddr), .done_global(done_global),
      .done_user(done_user), .done_writable(done_writable),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // memory model: stalls grants and varies response delay
   bit [31:0] mem [bit [31:0]];
   logic [2:0]  gcnt = '0;
   logic [1:0]  pend_cnt = '0;
   logic [31:0] pend_addr = '0;
   logic [31:0] pend_data = '0;
   logic        pend_we = 1'b0;
   int          nrd = 0;
   int          nwr = 0;
   logic [31:0] rd_log [0:255];

   assign mem_gnt = (gcnt[1:0] != 2'd3);

   always @(posedge clk) begin
      gcnt       <= gcnt + 3'd1;
      mem_rvalid <= 1'b0;
      if (pend_cnt != 2'd0) begin
         pend_cnt <= pend_cnt - 2'd1;
         if (pend_cnt == 2'd1) begin
            mem_rvalid <= 1'b1;
            if (pend_we) begin
               mem[pend_addr] = pend_data;
               mem_rdata <= 32'h0;
            end else begin
               mem_rdata <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            end
         end
      end
      if (mem_req && mem_gnt) begin
         pend_addr <= mem_addr;
         pend_data <= mem_wdata;
         pend_we   <= mem_we;
         pend_cnt  <= gcnt[0] ? 2'd1 : 2'd2;
         if (mem_we) nwr = nwr + 1;
         else begin
            rd_log[nrd[7:0]] = mem_addr;
            nrd = nrd + 1;
         end
      end
   end

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_combo(input int combo);
      int unsigned pc, tc;
      bit          we;
      logic [9:0]  di, ti;
      logic [11:0] off;
      logic [31:0] va, pde, pte, pde_a, pte_a, pte_new, pde_exp, pte_exp;
      logic [19:0] ppn;
      bit pde_ok, pte_ok, fault, pde_wr, pte_wr;
      int rd0, wr0, waited;
      bit prev_rsp, got, timing_ok;
      pc  = combo & 3;
      tc  = (combo >> 2) & 3;
      we  = combo[4];
      di  = 10'((combo*37 + 3) & 1023);
      ti  = 10'((combo*53 + 11) & 1023);
      off = 12'((combo*13) & 4095);
      va  = {di, ti, off};
      dir_base = 20'h00400 + 20'(combo);
      pde_a = {dir_base, di, 2'b00};
      pde = 32'h0100_0000 + (32'(combo) << 12) + 32'h0000_0E00;
      case (pc)
         0: pde = pde | 32'h0000_0020;
         1: pde = pde | 32'h0000_00A1;
         2: pde = pde | 32'h0000_0003;
         default: pde = pde | 32'h0000_0027;
      endcase
      pte_a = {pde[31:12], ti, 2'b00};
      ppn = 20'hA5000 ^ 20'(combo*97);
      pte = {ppn, 12'h000};
      pte[8] = combo[0] ^ combo[2];
      pte[2] = combo[1];
      pte[1] = combo[3] ^ combo[4];
      case (tc)
         0: pte = pte | 32'h0000_0040;
         1: pte = pte | 32'h0000_0001;
         2: pte = pte | 32'h0000_0021;
         default: pte = pte | 32'h0000_0061;
      endcase
      mem.delete();
      mem[pde_a] = pde;
      mem[pte_a] = pte;
      pde_ok  = (pc >= 2);
      pte_ok  = pde_ok && (tc != 0);
      fault   = !pte_ok;
      pde_wr  = pde_ok && (pc == 2);
      pte_new = pte | 32'h20 | (we ? 32'h40 : 32'h0);
      pte_wr  = pte_ok && (pte_new != pte);
      pde_exp = pde_wr ? (pde | 32'h20) : pde;
      pte_exp = pte_ok ? pte_new : pte;
      rd0 = nrd; wr0 = nwr;

      @(negedge clk);
      walk_req = 1'b1; walk_va = va; walk_write = we;
      @(negedge clk);
      walk_req = 1'b0; walk_va = ~va;
      waited = 0; got = 1'b0; timing_ok = 1'b0; prev_rsp = 1'b0;
      while (!got && waited < 200) begin
         if (waited == 2) walk_req = 1'b1;   // R10: ignored while busy
         if (waited == 3) walk_req = 1'b0;
         if (done_valid) begin
            got = 1'b1;
            timing_ok = prev_rsp;
         end else begin
            prev_rsp = mem_rvalid;
            @(negedge clk);
            waited++;
         end
      end
      chk(got, $sformatf("R8 combo %0d result arrived", combo), 32'(got), 32'd1);
      chk(timing_ok, $sformatf("R8 combo %0d one cycle after last response", combo), 32'(timing_ok), 32'd1);
      chk(done_fault == fault, $sformatf("R3/R4 combo %0d fault", combo), 32'(done_fault), 32'(fault));
      if (!fault) begin
         chk(done_ppn == ppn, $sformatf("R7 combo %0d ppn", combo), 32'(done_ppn), 32'(ppn));
         chk(done_paddr == {ppn, off}, $sformatf("R7 combo %0d paddr", combo), done_paddr, {ppn, off});
         chk({done_global, done_user, done_writable} == {pte[8], pte[2], pte[1]},
             $sformatf("R7 combo %0d perms", combo),
             32'({done_global, done_user, done_writable}), 32'({pte[8], pte[2], pte[1]}));
      end else begin
         chk(done_ppn == '0, $sformatf("R3 combo %0d ppn on fault", combo), 32'(done_ppn), 32'd0);
      end
      @(negedge clk);
      chk(!done_valid, $sformatf("R8 combo %0d pulse width", combo), 32'(done_valid), 32'd0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (done_valid || walk_busy)
            chk(1'b0, $sformatf("R10 combo %0d stray activity", combo), 32'({done_valid, walk_busy}), 32'd0);
      end
      chk(nrd - rd0 == (pde_ok ? 2 : 1), $sformatf("R3/R4/R10 combo %0d read count", combo),
          32'(nrd - rd0), pde_ok ? 32'd2 : 32'd1);
      chk(rd_log[rd0[7:0]] == pde_a, $sformatf("R1 combo %0d directory address", combo), rd_log[rd0[7:0]], pde_a);
      if (pde_ok)
         chk(rd_log[8'(rd0 + 1)] == pte_a, $sformatf("R2 combo %0d table address", combo), rd_log[8'(rd0 + 1)], pte_a);
      chk(nwr - wr0 == int'(pde_wr) + int'(pte_wr), $sformatf("R5/R6 combo %0d write count", combo),
          32'(nwr - wr0), 32'(int'(pde_wr) + int'(pte_wr)));
      chk(mem[pde_a] == pde_exp, $sformatf("R5 combo %0d directory entry", combo), mem[pde_a], pde_exp);
      chk(mem[pte_a] == pte_exp, $sformatf("R6 combo %0d table entry", combo), mem[pte_a], pte_exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!walk_busy && !done_valid && !mem_req, "R11 reset state",
          32'({walk_busy, done_valid, mem_req}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!walk_busy && !mem_req, "R11 idle after reset", 32'({walk_busy, mem_req}), 32'd0);
      for (int c = 0; c < 32; c++) run_combo(c);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule